// File: doc/BRIEF.md
# Multicycle Shared-Bus Register Processor

This block is a small processor core built around one 16-bit internal bus. It holds eight general registers, an operand latch A, a result latch G, a four-function ALU, a 9-bit instruction register and a step counter. Instruction words and immediate operands both arrive on the `din` input. Every data transfer, whether a register copy, an immediate load or an ALU operation, is one bus transfer per clock. Exactly one source drives the bus in each step, and a one-hot write enable selects the destination.

Each instruction starts with a fetch step that loads the instruction register from `din`. A register copy or an immediate load then finishes in one more step. An ALU instruction needs three more steps: it latches Ry into A, computes A op Rx into G, then writes G back to Rx. `done` is high during the final step of every instruction. The `run` input gates all progress. The register file and the bus are brought out so that a host or a bench can observe them.

Top module: `mcp_cpu`

## Requirements
- R1: While `rst_n` is low, `done` is 0 and the bus reads 0. Each clock edge with `rst_n` low clears every general register, A and G to zero and returns the step counter to the fetch step. The first step after `rst_n` rises is therefore a fetch.
- R2: In the fetch step, the instruction register loads `din[8:0]` at the clock edge, `done` is 0, no register is written and the bus reads 0. The opcode is bits 8:6, the Rx field is bits 5:3 and the Ry field is bits 2:0.
- R3: Opcode 000 (register copy) drives Ry onto the bus in the step after fetch, writes the bus into Rx at the end of that step, and raises `done` in that step. The next step is a fetch.
- R4: Opcode 001 (immediate load) drives `din` onto the bus in the step after fetch, writes it into Rx at the end of that step, and raises `done` in that step.
- R5: An ALU instruction runs three steps after fetch. In the first, Ry is on the bus and is latched into A. In the second, Rx is on the bus and A op bus is latched into G. In the third, G is on the bus and is written into Rx. `done` is high only in the third step.
- R6: Opcode 010 writes Ry + Rx into Rx, modulo 2^16.
- R7: Opcode 011 writes Ry − Rx into Rx, modulo 2^16.
- R8: Opcode 100 writes Ry AND Rx into Rx. Opcode 101 writes Ry OR Rx into Rx.
- R9: Opcodes 110 and 111 behave exactly as opcode 100 (bitwise AND, three steps).
- R10: While `run` is low and `rst_n` is high, the step counter, the instruction register, the general registers, A and G all hold. `done` is 0 and the bus reads 0. When `run` rises again, the interrupted instruction resumes at the step where it stopped.
- R11: When Rx and Ry name the same register, the value written is computed from that register's value before the write. A copy leaves the register unchanged, and an add doubles it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Step enable; progress only while high |
| din | input | 16 | Instruction word during fetch, immediate data during an immediate load |
| done | output | 1 | High in the last step of an instruction |
| bus_o | output | 16 | Current value of the internal shared bus |
| reg_view | output | 128 | General registers, register i at bits 16*i+15 : 16*i |

## Verification
The bench goes after operand order first. A subtract whose Rx and Ry differ would store Rx − Ry, not Ry − Rx, if the order were reversed. Sums that wrap past 0xFFFF would show a carry leak. The two unused opcodes are chosen so that AND gives a different result from ADD or OR. An instruction whose Rx equals Ry would expose a write that clobbers its own source. The bench also drops `run` in the middle of an ALU instruction: a counter that kept stepping would raise `done` a step early or write a stale G. A reset in the middle of an instruction must leave the next instruction starting cleanly at fetch.

// File: rtl/mcp_pkg.sv
package mcp_pkg;

   localparam int OPC_W = 3;

   localparam logic [OPC_W-1:0] OPC_MOV  = 3'b000;
   localparam logic [OPC_W-1:0] OPC_MOVI = 3'b001;
   localparam logic [OPC_W-1:0] OPC_ADD  = 3'b010;
   localparam logic [OPC_W-1:0] OPC_SUB  = 3'b011;
   localparam logic [OPC_W-1:0] OPC_AND  = 3'b100;
   localparam logic [OPC_W-1:0] OPC_OR   = 3'b101;

   typedef enum logic [1:0] {
      ALU_ADD = 2'b00,
      ALU_SUB = 2'b01,
      ALU_AND = 2'b10,
      ALU_OR  = 2'b11
   } alu_sel_e;

   // per-step control word, shared between decoder, counter and datapath
   typedef struct packed {
      logic     din_drv;
      logic     g_drv;
      logic     a_ld;
      logic     g_ld;
      alu_sel_e alu;
      logic     clr;
      logic     done;
   } ctrl_t;

endpackage

// File: rtl/mcp_step_ctr.sv
module mcp_step_ctr #(
   parameter  int STEPS = 4,
   localparam int SW    = $clog2(STEPS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          clr,
   output logic [SW-1:0] step
);

   generate
      if (STEPS < 4) begin : g_bad_steps
         $error("mcp_step_ctr: STEPS must be at least 4");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || clr)
         step <= '0;
      else if (run)
         step <= step + SW'(1);
   end

   // R10
   hold_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !clr) |=> $stable(step));

   // R3
   clear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (step == '0));

endmodule

// File: rtl/mcp_ctrl.sv
module mcp_ctrl
   import mcp_pkg::*;
#(
   parameter  int NREG  = 8,
   parameter  int SW    = 2,
   localparam int SEL_W = $clog2(NREG),
   localparam int IR_W  = OPC_W + 2*SEL_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic [IR_W-1:0] din_ir,
   input  logic [SW-1:0]   step,
   output ctrl_t           ctl,
   output logic [NREG-1:0] rd_sel,
   output logic [NREG-1:0] wr_sel
);

   localparam logic [SW-1:0] S_FETCH = SW'(0);
   localparam logic [SW-1:0] S_ONE   = SW'(1);
   localparam logic [SW-1:0] S_TWO   = SW'(2);
   localparam logic [SW-1:0] S_THREE = SW'(3);

   logic [IR_W-1:0]  ir_q;
   logic             ir_ld;
   logic [OPC_W-1:0] opc;
   logic [SEL_W-1:0] fx, fy;
   logic [NREG-1:0]  x_oh, y_oh;
   logic             is_move;
   alu_sel_e         alu_pick;

   assign opc  = ir_q[IR_W-1 -: OPC_W];
   assign fx   = ir_q[2*SEL_W-1 -: SEL_W];
   assign fy   = ir_q[SEL_W-1:0];
   assign x_oh = NREG'(1) << fx;
   assign y_oh = NREG'(1) << fy;
   assign is_move = (opc == OPC_MOV) || (opc == OPC_MOVI);

   always_comb begin
      case (opc)
         OPC_ADD: alu_pick = ALU_ADD;
         OPC_SUB: alu_pick = ALU_SUB;
         OPC_OR:  alu_pick = ALU_OR;
         default: alu_pick = ALU_AND;
      endcase
   end

   always_comb begin
      ctl    = '0;
      ir_ld  = 1'b0;
      rd_sel = '0;
      wr_sel = '0;
      if (!rst_n) begin
         ir_ld   = 1'b1;
         ctl.clr = 1'b1;
      end else if (run) begin
         case (step)
            S_FETCH: ir_ld = 1'b1;
            S_ONE: begin
               if (opc == OPC_MOV) begin
                  rd_sel   = y_oh;
                  wr_sel   = x_oh;
                  ctl.done = 1'b1;
                  ctl.clr  = 1'b1;
               end else if (opc == OPC_MOVI) begin
                  ctl.din_drv = 1'b1;
                  wr_sel      = x_oh;
                  ctl.done    = 1'b1;
                  ctl.clr     = 1'b1;
               end else begin
                  rd_sel   = y_oh;
                  ctl.a_ld = 1'b1;
               end
            end
            S_TWO: begin
               if (is_move) begin
                  ctl.clr = 1'b1;
               end else begin
                  rd_sel   = x_oh;
                  ctl.g_ld = 1'b1;
                  ctl.alu  = alu_pick;
               end
            end
            S_THREE: begin
               if (is_move) begin
                  ctl.clr = 1'b1;
               end else begin
                  ctl.g_drv = 1'b1;
                  wr_sel    = x_oh;
                  ctl.done  = 1'b1;
                  ctl.clr   = 1'b1;
               end
            end
            default: ctl.clr = 1'b1;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (ir_ld)
         ir_q <= din_ir;
   end

   // R2
   ir_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && step == S_FETCH) |=> (ir_q == $past(din_ir)));

   // R10
   ir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run) |=> $stable(ir_q));

endmodule

// File: rtl/mcp_alu.sv
module mcp_alu
   import mcp_pkg::*;
#(
   parameter int DATA_W        = 16,
   parameter bit ADDSUB_SHARED = 1'b1
) (
   input  alu_sel_e          sel,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] y
);

   logic [DATA_W-1:0] arith;

   generate
      if (ADDSUB_SHARED) begin : g_shared
         logic              sub;
         logic [DATA_W-1:0] b_eff;
         assign sub   = (sel == ALU_SUB);
         assign b_eff = sub ? ~b : b;
         assign arith = a + b_eff + DATA_W'(sub);
      end else begin : g_split
         logic [DATA_W-1:0] sum, dif;
         assign sum   = a + b;
         assign dif   = a - b;
         assign arith = (sel == ALU_SUB) ? dif : sum;
      end
   endgenerate

   always_comb begin
      case (sel)
         ALU_AND: y = a & b;
         ALU_OR:  y = a | b;
         default: y = arith;
      endcase
   end

endmodule

// File: rtl/mcp_datapath.sv
module mcp_datapath
   import mcp_pkg::*;
#(
   parameter int DATA_W        = 16,
   parameter int NREG          = 8,
   parameter bit ADDSUB_SHARED = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [DATA_W-1:0]      din,
   input  logic                   din_drv,
   input  logic                   g_drv,
   input  logic                   a_ld,
   input  logic                   g_ld,
   input  alu_sel_e               alu,
   input  logic [NREG-1:0]        rd_sel,
   input  logic [NREG-1:0]        wr_sel,
   output logic [DATA_W-1:0]      bus,
   output logic [NREG*DATA_W-1:0] reg_flat
);

   logic [DATA_W-1:0] rf [NREG];
   logic [DATA_W-1:0] reg_or;
   logic [DATA_W-1:0] a_q, g_q, alu_y;

   generate
      for (genvar i = 0; i < NREG; i++) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n)
               rf[i] <= '0;
            else if (wr_sel[i])
               rf[i] <= bus;
         end
         assign reg_flat[i*DATA_W +: DATA_W] = rf[i];
      end
   endgenerate

   always_comb begin
      reg_or = '0;
      for (int i = 0; i < NREG; i++)
         if (rd_sel[i]) reg_or = reg_or | rf[i];
   end

   // fixed priority: external data, then result latch, then registers
   always_comb begin
      if (din_drv)    bus = din;
      else if (g_drv) bus = g_q;
      else            bus = reg_or;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_q <= '0;
         g_q <= '0;
      end else begin
         if (a_ld) a_q <= bus;
         if (g_ld) g_q <= alu_y;
      end
   end

   mcp_alu #(.DATA_W(DATA_W), .ADDSUB_SHARED(ADDSUB_SHARED)) alu_i (
      .sel (alu),
      .a   (a_q),
      .b   (bus),
      .y   (alu_y)
   );

   // R5
   a_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      a_ld |=> (a_q == $past(bus)));

   // R6
   add_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (g_ld && alu == ALU_ADD) |=> (g_q == DATA_W'($past(a_q) + $past(bus))));

   // R7
   sub_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (g_ld && alu == ALU_SUB) |=> (g_q == DATA_W'($past(a_q) - $past(bus))));

   // R10
   regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sel == '0) |=> $stable(reg_flat));

endmodule

// File: rtl/mcp_cpu.sv
module mcp_cpu
   import mcp_pkg::*;
#(
   parameter  int DATA_W        = 16,
   parameter  int NREG          = 8,
   parameter  int STEPS         = 4,
   parameter  bit ADDSUB_SHARED = 1'b1,
   localparam int SEL_W         = $clog2(NREG),
   localparam int IR_W          = OPC_W + 2*SEL_W,
   localparam int SW            = $clog2(STEPS)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   run,
   input  logic [DATA_W-1:0]      din,
   output logic                   done,
   output logic [DATA_W-1:0]      bus_o,
   output logic [NREG*DATA_W-1:0] reg_view
);

   generate
      if ((1 << SEL_W) != NREG || NREG < 2) begin : g_bad_nreg
         $error("mcp_cpu: NREG must be a power of two, at least 2");
      end
      if (IR_W > DATA_W) begin : g_bad_ir
         $error("mcp_cpu: instruction word wider than data input");
      end
   endgenerate

   ctrl_t           ctl;
   logic [SW-1:0]   step;
   logic [NREG-1:0] rd_sel, wr_sel;

   mcp_step_ctr #(.STEPS(STEPS)) step_i (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (run),
      .clr  (ctl.clr),
      .step (step)
   );

   mcp_ctrl #(.NREG(NREG), .SW(SW)) ctrl_i (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .din_ir(din[IR_W-1:0]),
      .step  (step),
      .ctl   (ctl),
      .rd_sel(rd_sel),
      .wr_sel(wr_sel)
   );

   mcp_datapath #(.DATA_W(DATA_W), .NREG(NREG), .ADDSUB_SHARED(ADDSUB_SHARED)) dp_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .din     (din),
      .din_drv (ctl.din_drv),
      .g_drv   (ctl.g_drv),
      .a_ld    (ctl.a_ld),
      .g_ld    (ctl.g_ld),
      .alu     (ctl.alu),
      .rd_sel  (rd_sel),
      .wr_sel  (wr_sel),
      .bus     (bus_o),
      .reg_flat(reg_view)
   );

   assign done = ctl.done;

   // R3
   done_refetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (step == '0));

   // R5
   single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_sel));

endmodule

// File: tb/mcp_cpu_tb_top.sv
module mcp_cpu_tb_top;

   typedef struct packed {
      logic [2:0]  op;
      logic [2:0]  x;
      logic [2:0]  y;
      logic [15:0] imm;
      logic [15:0] exp;
   } vec_t;

   localparam int NV = 17;
   localparam vec_t VEC [NV] = '{
      '{3'b001, 3'd0, 3'd0, 16'h0005, 16'h0005},
      '{3'b001, 3'd1, 3'd0, 16'h0003, 16'h0003},
      '{3'b001, 3'd7, 3'd0, 16'hFFFF, 16'hFFFF},
      '{3'b010, 3'd0, 3'd1, 16'h0000, 16'h0008},
      '{3'b011, 3'd1, 3'd0, 16'h0000, 16'h0005},
      '{3'b011, 3'd2, 3'd1, 16'h0000, 16'h0005},
      '{3'b000, 3'd3, 3'd7, 16'h0000, 16'hFFFF},
      '{3'b010, 3'd3, 3'd1, 16'h0000, 16'h0004},
      '{3'b011, 3'd0, 3'd4, 16'h0000, 16'hFFF8},
      '{3'b001, 3'd5, 3'd0, 16'h00F0, 16'h00F0},
      '{3'b001, 3'd6, 3'd0, 16'h3C3C, 16'h3C3C},
      '{3'b100, 3'd6, 3'd5, 16'h0000, 16'h0030},
      '{3'b101, 3'd4, 3'd6, 16'h0000, 16'h0030},
      '{3'b110, 3'd5, 3'd3, 16'h0000, 16'h0000},
      '{3'b111, 3'd2, 3'd7, 16'h0000, 16'h0005},
      '{3'b000, 3'd1, 3'd1, 16'h0000, 16'h0005},
      '{3'b010, 3'd2, 3'd2, 16'h0000, 16'h000A}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run = 1'b0;
   logic [15:0] din = '0;
   logic        done;
   logic [15:0] bus_o;
   logic [127:0] reg_view;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;
   logic [15:0] model [8];

   always #10ns clk = ~clk;

   mcp_cpu dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .din     (din),
      .done    (done),
      .bus_o   (bus_o),
      .reg_view(reg_view)
   );

   function automatic logic [15:0] rv(input int i);
      return reg_view[i*16 +: 16];
   endfunction

   function automatic logic [15:0] ref_alu(input logic [2:0] op, input logic [15:0] a, b);
      case (op)
         3'b010:  return a + b;
         3'b011:  return a - b;
         3'b101:  return a | b;
         default: return a & b;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic chk_regs(input string tag);
      for (int i = 0; i < 8; i++) chk(tag, rv(i), model[i]);
   endtask

   // entered just after a falling edge, in the fetch step
   task automatic do_instr(input logic [2:0] op, input logic [2:0] x, input logic [2:0] y,
                           input logic [15:0] imm, input string tag);
      logic [15:0] res;
      din = {7'b0, op, x, y};
      #1ns;
      chk("R2 fetch done", {15'b0, done}, 16'h0);
      chk("R2 fetch bus", bus_o, 16'h0);
      @(negedge clk);
      if (op == 3'b001) begin
         din = imm;
         #1ns;
         chk(tag, bus_o, imm);
         chk(tag, {15'b0, done}, 16'h1);
         model[x] = imm;
      end else if (op == 3'b000) begin
         #1ns;
         chk(tag, bus_o, model[y]);
         chk(tag, {15'b0, done}, 16'h1);
         model[x] = model[y];
      end else begin
         #1ns;
         chk("R5 step1 bus", bus_o, model[y]);
         chk("R5 step1 done", {15'b0, done}, 16'h0);
         @(negedge clk);
         #1ns;
         chk("R5 step2 bus", bus_o, model[x]);
         chk("R5 step2 done", {15'b0, done}, 16'h0);
         res = ref_alu(op, model[y], model[x]);
         @(negedge clk);
         #1ns;
         chk(tag, bus_o, res);
         chk("R5 step3 done", {15'b0, done}, 16'h1);
         model[x] = res;
      end
      @(negedge clk);
      #1ns;
      chk_regs(tag);
   endtask

   initial begin
      for (int i = 0; i < 8; i++) model[i] = '0;
      // R1: reset state
      repeat (3) @(negedge clk);
      #1ns;
      chk("R1 done", {15'b0, done}, 16'h0);
      chk("R1 bus", bus_o, 16'h0);
      chk_regs("R1 regs");
      @(negedge clk);
      rst_n = 1'b1;
      run   = 1'b1;

      // table walk
      for (int k = 0; k < NV; k++) begin
         string tag;
         case (VEC[k].op)
            3'b000:         tag = "R3";
            3'b001:         tag = "R4";
            3'b010:         tag = "R6";
            3'b011:         tag = "R7";
            3'b100, 3'b101: tag = "R8";
            default:        tag = "R9";
         endcase
         if (VEC[k].op != 3'b001 && VEC[k].x == VEC[k].y) tag = "R11";
         do_instr(VEC[k].op, VEC[k].x, VEC[k].y, VEC[k].imm, tag);
         chk({tag, " table"}, rv(int'(VEC[k].x)), VEC[k].exp);
      end

      // R10: stall during an add R1,R4
      din = {7'b0, 3'b010, 3'd1, 3'd4};
      @(negedge clk);
      #1ns;
      chk("R10 pre bus", bus_o, model[4]);
      @(negedge clk);
      run = 1'b0;
      #1ns;
      chk("R10 stalled done", {15'b0, done}, 16'h0);
      chk("R10 stalled bus", bus_o, 16'h0);
      repeat (3) @(negedge clk);
      #1ns;
      chk("R10 stalled bus late", bus_o, 16'h0);
      chk_regs("R10 regs held");
      run = 1'b1;
      #1ns;
      chk("R10 resume bus", bus_o, model[1]);
      chk("R10 resume done", {15'b0, done}, 16'h0);
      @(negedge clk);
      #1ns;
      chk("R10 result bus", bus_o, 16'h0035);
      chk("R10 result done", {15'b0, done}, 16'h1);
      @(negedge clk);
      #1ns;
      model[1] = 16'h0035;
      chk_regs("R10 regs after");

      // R1: reset in the middle of a subtract
      din = {7'b0, 3'b011, 3'd2, 3'd3};
      @(negedge clk);
      rst_n = 1'b0;
      #1ns;
      chk("R1 mid done", {15'b0, done}, 16'h0);
      chk("R1 mid bus", bus_o, 16'h0);
      @(negedge clk);
      #1ns;
      for (int i = 0; i < 8; i++) model[i] = '0;
      chk_regs("R1 mid regs");
      rst_n = 1'b1;
      do_instr(3'b001, 3'd3, 3'd0, 16'h1234, "R1 restart");
      do_instr(3'b010, 3'd3, 3'd3, 16'h0000, "R11 double");
      chk("R11 double value", rv(3), 16'h2468);

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      #3ms;
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL R5 watchdog: got 0 expected 1 (run did not complete)");
         $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

endmodule